// File: doc/BRIEF.md
# Loop-Bound Predicate Generator

This block builds the lane-enable mask for one pass of a loop whose vector width is set at run time. The caller supplies the current scalar loop position, the loop's exclusive upper bound, an element-size code and the active length value (each unit of length is 128 bits of vector). The block returns a byte-granular predicate with one bit per vector byte. It also returns the step by which the scalar position should advance for the next pass, and four condition flags for the loop-closing branch.

Element i of the pass is enabled when position + i is below the bound, under a signed comparison. Only the bit that sits at the lowest byte of each enabled element is set. The result is captured in output registers one clock after a request is presented with `in_valid`. The outputs keep their values until the next request arrives.

Top module: `loop_pred_gen`

## Requirements
- R1: For element index i in 0..E-1 (E = element count of the pass), predicate bit i*B is 1 exactly when in_index + i < in_limit, where both operands are IDX_W-bit two's-complement values compared with exact (non-wrapping) arithmetic.
- R2: The element-size code selects B bytes per element: code 0 = 1, code 1 = 2, code 2 = 4, code 3 = 8. E = 16*L/B. Every predicate bit that is not at byte offset i*B for some i < E is 0, and this includes all bits at or above byte 16*L.
- R3: out_step equals E, which is 16*L, 8*L, 4*L or 2*L for codes 0..3.
- R4: The effective length L is in_vlen, except that in_vlen = 0 gives L = 1 and in_vlen > MAX_VL gives L = MAX_VL.
- R5: The flags follow the predicate. out_flag_n = element 0 enabled. out_flag_z = no element enabled. out_flag_c = element E-1 not enabled. out_flag_v = 0.
- R6: out_valid is 1 in the cycle after a cycle with in_valid high and 0 otherwise, and the results of that request appear together with it.
- R7: While in_valid is low, out_pred, out_step and the flags keep their values whatever the data inputs do.
- R8: During reset, out_valid = 0, out_pred = 0, out_step = 0, out_flag_z = 1, and out_flag_n, out_flag_c and out_flag_v are 0.
- R9: For L = 4 with 8-byte elements, a pass at position 96 with bound 99 enables only elements 0..2 (predicate bits 0, 8, 16). A pass at position 88 enables all 8 elements.
- R10: Signed extremes are handled without wrap. Position = most negative with bound = most positive enables every element. Position = most positive with bound = most negative enables none. Negative positions and bounds compare as signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; captures the data inputs |
| in_index | input | IDX_W | Signed scalar loop position |
| in_limit | input | IDX_W | Signed exclusive loop bound |
| in_esize | input | 2 | Element-size code (0: 1 B, 1: 2 B, 2: 4 B, 3: 8 B) |
| in_vlen | input | VL_W | Requested length in 128-bit units |
| out_valid | output | 1 | Result present this cycle |
| out_pred | output | 16*MAX_VL | Byte-granular lane-enable mask |
| out_step | output | IDX_W | Scalar increment for the next pass |
| out_flag_n | output | 1 | First element enabled |
| out_flag_z | output | 1 | No element enabled |
| out_flag_c | output | 1 | Last element not enabled |
| out_flag_v | output | 1 | Always 0 |

## Verification
A wrong enabled-element count shows up one cycle after the request. It appears as a predicate whose population no longer matches the step and carry flag, or whose zero flag disagrees with the mask. A wrong lane-count or size decode shows up as bits at non-leading byte offsets or beyond the active length, and as a wrong step, in the same cycle. Sweeping every length (including the saturated values), every size code and a span of bound offsets around each pass edge exposes off-by-one and saturation faults on the first affected request. Output registers that capture without a strobe corrupt the held result on the next idle cycle.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE  = 2'd0,
      ESZ_HALF  = 2'd1,
      ESZ_WORD  = 2'd2,
      ESZ_DWORD = 2'd3
   } esize_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cond_flags_t;

   localparam int unsigned BYTES_PER_UNIT = 16;

endpackage

// File: rtl/lbp_lane_count.sv
module lbp_lane_count #(
   parameter int unsigned MAX_VL = 16,
   parameter int unsigned VL_W   = 5,
   parameter int unsigned CNT_W  = 9
) (
   input  logic [VL_W-1:0]  vlen,
   input  lbp_pkg::esize_e  esize,
   output logic [CNT_W-1:0] eff_vl,
   output logic [CNT_W-1:0] elem_cnt
);
   import lbp_pkg::*;

   if (VL_W < $clog2(MAX_VL + 1)) begin : g_bad_vlw
      $error("VL_W cannot hold MAX_VL");
   end

   always_comb begin
      if (vlen == '0) begin
         eff_vl = CNT_W'(1);
      end else if (vlen > VL_W'(MAX_VL)) begin
         eff_vl = CNT_W'(MAX_VL);
      end else begin
         eff_vl = CNT_W'(vlen);
      end
   end

   always_comb begin
      elem_cnt = (eff_vl << 4) >> esize;
   end

endmodule

// File: rtl/lbp_active_count.sv
module lbp_active_count #(
   parameter int unsigned IDX_W = 64,
   parameter int unsigned CNT_W = 9
) (
   input  logic [IDX_W-1:0] index,
   input  logic [IDX_W-1:0] limit,
   input  logic [CNT_W-1:0] elem_cnt,
   output logic [CNT_W-1:0] act_cnt
);

   if (IDX_W < CNT_W) begin : g_bad_idxw
      $error("IDX_W must be at least CNT_W");
   end

   logic signed [IDX_W:0] remain;

   always_comb begin
      remain = $signed({limit[IDX_W-1], limit}) - $signed({index[IDX_W-1], index});
   end

   always_comb begin
      if (remain[IDX_W] || (remain == '0)) begin
         act_cnt = '0;
      end else if (remain[IDX_W-1:0] >= IDX_W'(elem_cnt)) begin
         act_cnt = elem_cnt;
      end else begin
         act_cnt = remain[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/lbp_mask_expand.sv
module lbp_mask_expand #(
   parameter int unsigned PRED_W = 256,
   parameter int unsigned CNT_W  = 9
) (
   input  lbp_pkg::esize_e   esize,
   input  logic [CNT_W-1:0]  act_cnt,
   output logic [PRED_W-1:0] pred
);
   import lbp_pkg::*;

   logic [2:0] low_mask;

   always_comb begin
      case (esize)
         ESZ_BYTE:  low_mask = 3'b000;
         ESZ_HALF:  low_mask = 3'b001;
         ESZ_WORD:  low_mask = 3'b011;
         default:   low_mask = 3'b111;
      endcase
   end

   for (genvar b = 0; b < PRED_W; b++) begin : g_byte
      logic lead;
      logic [CNT_W-1:0] elem_idx;
      always_comb begin
         lead     = ((3'(b) & low_mask) == 3'd0);
         elem_idx = CNT_W'(b) >> esize;
         pred[b]  = lead && (elem_idx < act_cnt);
      end
   end

endmodule

// File: rtl/loop_pred_gen.sv
module loop_pred_gen #(
   parameter int unsigned IDX_W  = 64,
   parameter int unsigned MAX_VL = 16,
   parameter int unsigned VL_W   = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [IDX_W-1:0]            in_index,
   input  logic [IDX_W-1:0]            in_limit,
   input  logic [1:0]                  in_esize,
   input  logic [VL_W-1:0]             in_vlen,
   output logic                        out_valid,
   output logic [16*MAX_VL-1:0]        out_pred,
   output logic [IDX_W-1:0]            out_step,
   output logic                        out_flag_n,
   output logic                        out_flag_z,
   output logic                        out_flag_c,
   output logic                        out_flag_v
);
   import lbp_pkg::*;

   localparam int unsigned PRED_W = BYTES_PER_UNIT * MAX_VL;
   localparam int unsigned CNT_W  = $clog2(PRED_W + 1);

   if (MAX_VL < 1) begin : g_bad_maxvl
      $error("MAX_VL must be at least 1");
   end
   if (IDX_W < 8) begin : g_bad_idx
      $error("IDX_W must be at least 8");
   end

   esize_e            esz;
   logic [CNT_W-1:0]  eff_vl;
   logic [CNT_W-1:0]  elem_cnt;
   logic [CNT_W-1:0]  act_cnt;
   logic [PRED_W-1:0] pred_c;
   cond_flags_t       flags_c;
   cond_flags_t       flags_q;

   assign esz = esize_e'(in_esize);

   lbp_lane_count #(.MAX_VL(MAX_VL), .VL_W(VL_W), .CNT_W(CNT_W)) u_lanes (
      .vlen     (in_vlen),
      .esize    (esz),
      .eff_vl   (eff_vl),
      .elem_cnt (elem_cnt)
   );

   lbp_active_count #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_active (
      .index    (in_index),
      .limit    (in_limit),
      .elem_cnt (elem_cnt),
      .act_cnt  (act_cnt)
   );

   lbp_mask_expand #(.PRED_W(PRED_W), .CNT_W(CNT_W)) u_mask (
      .esize    (esz),
      .act_cnt  (act_cnt),
      .pred     (pred_c)
   );

   always_comb begin
      flags_c.n = (act_cnt != '0);
      flags_c.z = (act_cnt == '0);
      flags_c.c = (act_cnt < elem_cnt);
      flags_c.v = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pred  <= '0;
         out_step  <= '0;
         flags_q   <= '{n: 1'b0, z: 1'b1, c: 1'b0, v: 1'b0};
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_pred <= pred_c;
            out_step <= IDX_W'(elem_cnt);
            flags_q  <= flags_c;
         end
      end
   end

   assign out_flag_n = flags_q.n;
   assign out_flag_z = flags_q.z;
   assign out_flag_c = flags_q.c;
   assign out_flag_v = flags_q.v;

   // R6
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R6
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R7
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_pred) && $stable(out_step) && $stable(flags_q)));
   // R5
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_z == (out_pred == '0));
   // R5
   first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_n == out_pred[0]);
   // R5
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_flag_v);
   // R1
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_pred) <= int'(out_step));
   // R5
   carry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_flag_c) |-> ($countones(out_pred) == int'(out_step)));

endmodule

// File: tb/loop_pred_gen_tb.sv
module loop_pred_gen_tb;
   localparam int MAXV = 4;
   localparam int PW   = 16 * MAXV;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [63:0]   in_index = '0;
   logic [63:0]   in_limit = '0;
   logic [1:0]    in_esize = '0;
   logic [4:0]    in_vlen = '0;
   logic          out_valid;
   logic [PW-1:0] out_pred;
   logic [63:0]   out_step;
   logic          out_flag_n, out_flag_z, out_flag_c, out_flag_v;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   loop_pred_gen #(.IDX_W(64), .MAX_VL(MAXV), .VL_W(5)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_index(in_index), .in_limit(in_limit), .in_esize(in_esize), .in_vlen(in_vlen),
      .out_valid(out_valid), .out_pred(out_pred), .out_step(out_step),
      .out_flag_n(out_flag_n), .out_flag_z(out_flag_z),
      .out_flag_c(out_flag_c), .out_flag_v(out_flag_v)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [63:0] idx, input logic [63:0] lim,
                        input int esz, input int vl,
                        output logic [63:0] pred, output int step,
                        output logic fn, output logic fz, output logic fc);
      int l;
      int ec;
      int cnt;
      logic signed [64:0] rem;
      l   = (vl == 0) ? 1 : ((vl > MAXV) ? MAXV : vl);
      ec  = (16 * l) >> esz;
      rem = $signed({lim[63], lim}) - $signed({idx[63], idx});
      if (rem <= 0) cnt = 0;
      else if (rem >= ec) cnt = ec;
      else cnt = int'(rem);
      pred = '0;
      for (int e = 0; e < cnt; e++) pred[e << esz] = 1'b1;
      step = ec;
      fn = (cnt > 0);
      fz = (cnt == 0);
      fc = (cnt < ec);
   endtask

   task automatic issue(input logic [63:0] idx, input logic [63:0] lim,
                        input int esz, input int vl);
      @(negedge clk);
      in_index = idx;
      in_limit = lim;
      in_esize = 2'(esz);
      in_vlen  = 5'(vl);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_one(input logic [63:0] idx, input logic [63:0] lim,
                          input int esz, input int vl, input string tag);
      logic [63:0] ep;
      int es;
      logic en, ez, ec;
      model(idx, lim, esz, vl, ep, es, en, ez, ec);
      issue(idx, lim, esz, vl);
      chk({tag, " R1 R2 R4 pred"}, out_pred, ep);
      chk({tag, " R3 step"}, out_step, 64'(es));
      chk({tag, " R5 flags nzcv"}, {60'd0, out_flag_n, out_flag_z, out_flag_c, out_flag_v},
          {60'd0, en, ez, ec, 1'b0});
   endtask

   initial begin
      logic [63:0] held_pred;
      logic [63:0] held_step;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 valid", {63'd0, out_valid}, 64'd0);
      chk("R8 pred", out_pred, 64'd0);
      chk("R8 step", out_step, 64'd0);
      chk("R8 flags", {60'd0, out_flag_n, out_flag_z, out_flag_c, out_flag_v}, 64'h4);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 partial last pass and full pass
      issue(64'd96, 64'd99, 3, 4);
      chk("R9 last pass pred", out_pred, 64'h0000_0000_0001_0101);
      chk("R9 last pass step", out_step, 64'd8);
      chk("R6 valid after request", {63'd0, out_valid}, 64'd1);
      @(negedge clk);
      chk("R6 valid drops", {63'd0, out_valid}, 64'd0);
      issue(64'd88, 64'd99, 3, 4);
      chk("R9 full pass pred", out_pred, 64'h0101_0101_0101_0101);

      // R7 inputs ignored while idle
      held_pred = out_pred;
      held_step = out_step;
      @(negedge clk);
      in_index = 64'd0; in_limit = 64'd1; in_esize = 2'd0; in_vlen = 5'd1;
      @(negedge clk);
      @(negedge clk);
      chk("R7 pred held", out_pred, held_pred);
      chk("R7 step held", out_step, held_step);
      chk("R7 carry held", {63'd0, out_flag_c}, 64'd0);

      // R10 signed extremes
      run_one(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 4, "R10 full span");
      run_one(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 4, "R10 reversed");
      run_one(-64'sd5, -64'sd2, 1, 2, "R10 negatives");
      run_one(-64'sd2, 64'sd1, 3, 1, "R10 sign cross");

      // R1 R2 R3 R4 R5 sweep
      for (int b = 0; b < 3; b++) begin
         for (int vl = 0; vl < 7; vl++) begin
            for (int esz = 0; esz < 4; esz++) begin
               for (int d = -3; d < 67; d++) begin
                  logic [63:0] base;
                  base = (b == 0) ? 64'd0 : ((b == 1) ? -64'sd50 : 64'd1000);
                  run_one(base, base + 64'(d), esz, vl, "sweep");
               end
            end
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R6 actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule